// File: doc/BRIEF.md
# Interrupt Request Aggregator

The block gathers up to 32 interrupt request lines into one request summary word. A processor reads that word and programs the block through a small register interface. Each line can be set to level or edge sensitivity, and its active level can be set to high or low. An enable mask selects which summarised lines drive the single combined interrupt output to the CPU.

Bit 31 carries a request cascaded from a legacy bus interrupt controller. Bits 0 to 19 carry peripheral slot lines. A parameter names the valid bits, so a board variant can expose a different subset; bits outside that set always read as zero. An edge event is dismissed by writing a one to the line's bit in the clear register and then writing zero. Writing one key value to the reset trigger register sends a one-cycle system reset request.

Top module: `irq_aggregator`

## Requirements
- R1: The CPU interrupt output is high in exactly those cycles when the summary AND the enable mask is non-zero. An enable bit of 1 enables its line.
- R2: After reset, the enable, edge-select, polarity and clear registers hold zero, and the reset request output is low.
- R3: Bits outside VALID_BITS (default 0x800F_FFFF, so bits 20 to 30 are reserved) read as zero in every register. Writes to those bits are dropped.
- R4: A polarity bit of 1 makes its line active-high. A polarity bit of 0 makes it active-low. The line's active state is the input XNOR the polarity bit.
- R5: A line whose edge-select bit is 0 is level-sensitive. Its summary bit equals its active state in the same cycle, with no latching.
- R6: A line whose edge-select bit is 1 sets a pending bit at a clock edge where its active state is 1 and was 0 at the previous edge. The pending bit is its summary bit and holds until it is cleared. Turning edge mode off drops it.
- R7: While a line's clear bit is 1, its pending bit is forced to 0, and edges seen in that time are lost. Writing zero to the clear register re-arms edge capture. The clear register reads back its written value.
- R8: The clear register has no effect on a level-sensitive line's summary bit.
- R9: Writing 0x0000_DEAD to the reset trigger register raises the reset request for exactly one cycle, starting the cycle after the write. Any other value is ignored. A key write made while the request is already high gives no second cycle.
- R10: Register map by word address: 0 summary (read-only, writes ignored), 1 enable, 2 edge select, 3 polarity, 4 clear, 5 reset trigger (reads zero). Addresses 6 and 7 read zero. Read data is combinational on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_lines | input | 32 | Raw interrupt request lines |
| cpu_irq | output | 1 | Combined interrupt to the CPU |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that irq_lines and the bus inputs are synchronous to clk and stable around its rising edge. They also assume at most one register write per cycle. The bench meets these conditions by changing every input only at the falling edge. It then drives random line patterns, random writes to every address (including the clear register in set-then-zero pairs), and both key and non-key writes to the reset trigger. Edge-mode pending bits are allowed to change only at clock edges, and the bench checks them after each edge.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int W = 32,
  parameter int AW = 3,
  parameter logic [W-1:0] VALID_BITS = 32'h800F_FFFF,
  parameter logic [W-1:0] RESET_KEY = 32'h0000_DEAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  irq_lines,
  output logic          cpu_irq,
  output logic          sys_reset_req
);

  localparam logic [AW-1:0] A_SUM  = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_TRIG = AW'(2);
  localparam logic [AW-1:0] A_POL  = AW'(3);
  localparam logic [AW-1:0] A_CLR  = AW'(4);
  localparam logic [AW-1:0] A_RST  = AW'(5);

  logic [W-1:0] en_q, trig_q, pol_q, clr_q, pend_q, act_q;
  logic [W-1:0] act, summary;
  logic         rst_q;

  assign act     = ~(irq_lines ^ pol_q);
  assign summary = VALID_BITS & ((trig_q & pend_q) | (~trig_q & act));
  assign cpu_irq = |(summary & en_q);
  assign sys_reset_req = rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      trig_q <= '0;
      pol_q  <= '0;
      clr_q  <= '0;
      pend_q <= '0;
      act_q  <= '0;
      rst_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q | (act & ~act_q)) & trig_q & ~clr_q & VALID_BITS;
      act_q  <= act;
      rst_q  <= bus_wr && bus_addr == A_RST && bus_wdata == RESET_KEY && !rst_q;
      if (bus_wr) begin
        case (bus_addr)
          A_EN:    en_q   <= bus_wdata & VALID_BITS;
          A_TRIG:  trig_q <= bus_wdata & VALID_BITS;
          A_POL:   pol_q  <= bus_wdata & VALID_BITS;
          A_CLR:   clr_q  <= bus_wdata & VALID_BITS;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_SUM:   bus_rdata = summary;
      A_EN:    bus_rdata = en_q;
      A_TRIG:  bus_rdata = trig_q;
      A_POL:   bus_rdata = pol_q;
      A_CLR:   bus_rdata = clr_q;
      default: bus_rdata = '0;
    endcase
  end

  a_r1_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !cpu_irq);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~VALID_BITS) == '0));

  a_r6_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q & trig_q & ~clr_q) & ~pend_q) == '0));

  a_r7_clear_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_q) & pend_q) == '0));

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);

  a_r9_key_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset_req) |-> $past(bus_wr && bus_addr == A_RST && bus_wdata == RESET_KEY));

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;
  localparam logic [31:0] VALID = 32'h800F_FFFF;
  localparam logic [31:0] KEY   = 32'h0000_DEAD;

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, irq_lines = 0;
  logic        cpu_irq, sys_reset_req;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_en, m_trig, m_pol, m_clr, m_pend, m_prev;
  logic        m_rst;

  always #2 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .cpu_irq(cpu_irq), .sys_reset_req(sys_reset_req));

  function automatic logic [31:0] m_act();
    return ~(irq_lines ^ m_pol);
  endfunction

  function automatic logic [31:0] m_sum();
    return VALID & ((m_trig & m_pend) | (~m_trig & m_act()));
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_sum();
      3'd1: return m_en;
      3'd2: return m_trig;
      3'd3: return m_pol;
      3'd4: return m_clr;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_en = 0; m_trig = 0; m_pol = 0; m_clr = 0; m_pend = 0; m_prev = 0; m_rst = 0;
  endtask

  task automatic cycle(logic wr, logic [2:0] a, logic [31:0] d, logic [31:0] lines);
    logic [31:0] act;
    bus_wr = wr; bus_addr = a; bus_wdata = d; irq_lines = lines;
    #1;
    check(a == 3'd0 ? "R3 R4 R5 R6 R7 R8 summary" : "R10 register read", bus_rdata, m_read(a));
    check("R1 cpu_irq", {31'b0, cpu_irq}, {31'b0, |(m_sum() & m_en)});
    check("R9 reset request", {31'b0, sys_reset_req}, {31'b0, m_rst});
    @(posedge clk);
    act = m_act();
    m_pend = (m_pend | (act & ~m_prev)) & m_trig & ~m_clr & VALID;
    m_prev = act;
    m_rst  = wr && a == 3'd5 && d == KEY && !m_rst;
    if (wr) case (a)
      3'd1: m_en   = d & VALID;
      3'd2: m_trig = d & VALID;
      3'd3: m_pol  = d & VALID;
      3'd4: m_clr  = d & VALID;
      default: ;
    endcase
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lines;
    void'($urandom(32'h1234));
    model_reset();
    repeat (3) @(negedge clk);
    // R2: reset state read through the bus
    for (int a = 1; a <= 4; a++) begin
      bus_addr = 3'(a); #1;
      check("R2 reset register", bus_rdata, 32'h0);
    end
    check("R2 reset request low", {31'b0, sys_reset_req}, 32'h0);
    rst_n = 1;
    @(negedge clk);

    // Directed: level, active-low default, reserved bits
    cycle(1, 3'd1, 32'hFFFF_FFFF, 32'h0);
    cycle(0, 3'd1, 0, 32'h0);            // R3 reserved bits of mask read zero
    cycle(0, 3'd0, 0, 32'h0000_0005);    // R4 R5 active-low level
    cycle(1, 3'd3, 32'hFFFF_FFFF, 32'h8000_0001);
    cycle(0, 3'd0, 0, 32'h8000_0001);    // R4 active-high
    cycle(1, 3'd4, 32'hFFFF_FFFF, 32'h8000_0001);
    cycle(0, 3'd0, 0, 32'h8000_0001);    // R8 clear no effect on level
    cycle(1, 3'd4, 0, 32'h0);
    // Edge: latch, hold, clear pair
    cycle(1, 3'd2, 32'h8000_000F, 32'h0);
    cycle(0, 3'd0, 0, 32'h0000_0003);
    cycle(0, 3'd0, 0, 32'h0);            // R6 held after input drops
    cycle(0, 3'd0, 0, 32'h0);
    cycle(1, 3'd4, 32'h0000_0001, 32'h0);
    cycle(0, 3'd0, 0, 32'h0000_0001);    // R7 edge while clear held lost
    cycle(1, 3'd4, 0, 32'h0);
    cycle(0, 3'd0, 0, 32'h0);
    cycle(1, 3'd0, 32'hFFFF_FFFF, 32'h0); // R10 summary write ignored
    cycle(0, 3'd0, 0, 32'h0);
    // Reset trigger
    cycle(1, 3'd5, 32'h0000_DEAE, 32'h0);
    cycle(0, 3'd5, 0, 32'h0);
    cycle(1, 3'd5, KEY, 32'h0);
    cycle(1, 3'd5, KEY, 32'h0);          // R9 back-to-back gives no second cycle
    cycle(0, 3'd6, 0, 32'h0);
    cycle(0, 3'd7, 0, 32'h0);

    // Random
    lines = 0;
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [2:0] a;
      logic [31:0] d;
      lines = lines ^ ($urandom() & $urandom() & $urandom());
      wr = ($urandom() % 4) == 0;
      a  = 3'($urandom() % 8);
      d  = $urandom();
      if (a == 3'd5 && ($urandom() % 2) == 0) d = KEY;
      if (a == 3'd4 && ($urandom() % 2) == 0) d = 0;
      cycle(wr, a, d, lines);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule